// File: doc/BRIEF.md
# Serial Control Port with I/O Expander

This block is a select-framed serial receiver. It takes one 16-bit control word per transaction and uses it to program twelve 8-bit converter code registers and a 12-pin general-purpose I/O expander. The serial clock, the active-low select and the serial data come from another clock domain. Each of them passes through a synchronizer clocked by the system clock `clk` before any edge is detected. Data is shifted in on rising serial-clock edges while select is low. The accumulated word takes effect when select returns high.

When select falls, the block samples the expander pins. That 12-bit snapshot then leaves on the serial output, least significant bit first, and the output advances on each falling serial-clock edge. Because the same register carries the incoming bits, a host can read back the pin levels, or several devices can be chained. The serial output has a separate enable, and the enable is low whenever select is high. Each expander pin has its own enable, so it is either a driven output or a high-impedance input.

The incoming word has two fields. Bits 15:12 hold an address and bits 11:0 hold a payload.

Top module: `serial_ctl_expander`

## Requirements
- R1: While reset is asserted and right after it, every expander enable (`exp_oe`) is 0, so all pins are inputs. The expander data (`exp_out`) is 0, every converter code is 0x00, and `sdo_oe` is 0.
- R2: A complete word with address 1 to 12 loads payload bits 7:0 into channel address−1. Channel n occupies `dac_code[8n+7:8n]`. Payload bits 11:8 and the other channels are unaffected.
- R3: A complete word with address 13 loads payload bits 11:0 into `exp_oe`, where 1 means the pin is an output.
- R4: A complete word with address 14 loads payload bits 11:0 into `exp_out`.
- R5: A complete word with address 0 or 15 changes none of `dac_code`, `exp_oe` or `exp_out`.
- R6: If select rises after fewer than 16 rising serial-clock edges, the word is dropped and no output register changes. This includes the case of zero edges.
- R7: Serial data is taken bit 0 first, one bit per rising serial-clock edge while select is low. No output register changes before select rises.
- R8: `sdo_oe` is 1 while select is low and 0 while it is high, after the synchronizer delay.
- R9: At the select fall, the expander pin levels are captured as bits 11:0 of the shift register, and bits 15:12 are 0. `sdo` shows bit 0 before the first serial clock and advances one bit per falling serial-clock edge.
- R10: With more than 16 rising edges in a frame, the last 16 bits received form the word. From the 17th bit position on, `sdo` shows the bits received at the start of the frame, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock |
| csn | input | 1 | Active-low select that frames a transaction |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial output enable |
| exp_in | input | 12 | Expander pin levels |
| exp_out | output | 12 | Expander output data |
| exp_oe | output | 12 | Expander per-pin output enable |
| dac_code | output | 96 | Twelve 8-bit converter codes, channel n at bits 8n+7:8n |

## Verification
A wrong bit count or a wrong shift direction shows up on `sdo` within one serial-clock period, because the readback bits arrive in the wrong order or at the wrong time. It also shows up a few system cycles after select rises: the update lands on the wrong register, or a short frame updates a register when it should not. A wrong address decode corrupts a single channel or the expander masks, and this is visible at the ports right after the commit. The bench therefore compares every output register after each frame, so that a neighbour disturbed by a commit is caught too. It also samples `sdo` before every rising serial-clock edge.

// File: rtl/serial_ctl_expander.sv
module serial_ctl_expander #(
  parameter int NUM_DAC     = 12,
  parameter int CODE_W      = 8,
  parameter int EXP_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      csn,
  input  logic                      sdi,
  output logic                      sdo,
  output logic                      sdo_oe,
  input  logic [EXP_W-1:0]          exp_in,
  output logic [EXP_W-1:0]          exp_out,
  output logic [EXP_W-1:0]          exp_oe,
  output logic [NUM_DAC*CODE_W-1:0] dac_code
);
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int ADDR_DIR = NUM_DAC + 1;
  localparam int ADDR_OUT = NUM_DAC + 2;

  logic [SYNC_STAGES:0]   sclk_sr, csn_sr;
  logic [SYNC_STAGES-1:0] sdi_sr;
  logic [EXP_W-1:0]       exp_sr [SYNC_STAGES];

  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sdo_q;
  logic [NUM_DAC-1:0][CODE_W-1:0] dac_q;
  logic [EXP_W-1:0]  oe_q, out_q;

  wire sclk_s = sclk_sr[SYNC_STAGES-1];
  wire sclk_d = sclk_sr[SYNC_STAGES];
  wire csn_s  = csn_sr[SYNC_STAGES-1];
  wire csn_d  = csn_sr[SYNC_STAGES];
  wire sdi_s  = sdi_sr[SYNC_STAGES-1];
  wire [EXP_W-1:0] exp_s = exp_sr[SYNC_STAGES-1];

  wire sh_rise   = !csn_s && sclk_s && !sclk_d;
  wire sh_fall   = !csn_s && !sclk_s && sclk_d;
  wire cs_fall   = !csn_s && csn_d;
  wire cs_rise   = csn_s && !csn_d;
  wire word_full = (bit_cnt == CNT_W'(WORD_W));
  wire commit    = cs_rise && word_full;
  wire [ADDR_W-1:0] addr = sreg[WORD_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      csn_sr  <= '1;
      sdi_sr  <= '0;
      for (int k = 0; k < SYNC_STAGES; k++) exp_sr[k] <= '0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-1:0], sclk};
      csn_sr  <= {csn_sr[SYNC_STAGES-1:0], csn};
      sdi_sr  <= {sdi_sr[SYNC_STAGES-2:0], sdi};
      exp_sr[0] <= exp_in;
      for (int k = 1; k < SYNC_STAGES; k++) exp_sr[k] <= exp_sr[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      bit_cnt <= '0;
      sdo_q   <= 1'b0;
    end else if (cs_fall) begin
      sreg    <= WORD_W'(exp_s);
      bit_cnt <= '0;
      sdo_q   <= exp_s[0];
    end else begin
      if (sh_rise) begin
        sreg <= {sdi_s, sreg[WORD_W-1:1]};
        if (!word_full) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sh_fall) sdo_q <= sreg[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      oe_q  <= '0;
      out_q <= '0;
    end else if (commit) begin
      for (int i = 0; i < NUM_DAC; i++)
        if (addr == ADDR_W'(i + 1)) dac_q[i] <= sreg[CODE_W-1:0];
      if (addr == ADDR_W'(ADDR_DIR)) oe_q  <= sreg[EXP_W-1:0];
      if (addr == ADDR_W'(ADDR_OUT)) out_q <= sreg[EXP_W-1:0];
    end
  end

  assign sdo      = sdo_q;
  assign sdo_oe   = !csn_s;
  assign exp_out  = out_q;
  assign exp_oe   = oe_q;
  assign dac_code = dac_q;
endmodule

// File: rtl/serial_ctl_expander_chk.sv
module serial_ctl_expander_chk #(
  parameter int NUM_DAC = 12,
  parameter int CODE_W  = 8,
  parameter int EXP_W   = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_rise,
  input logic                      word_full,
  input logic [3:0]                addr,
  input logic [4:0]                bit_cnt,
  input logic [NUM_DAC*CODE_W-1:0] dac_code,
  input logic [EXP_W-1:0]          exp_oe,
  input logic [EXP_W-1:0]          exp_out
);
  localparam logic [3:0] A_LAST = 4'(NUM_DAC);
  localparam logic [3:0] A_DIR  = 4'(NUM_DAC + 1);
  localparam logic [3:0] A_OUT  = 4'(NUM_DAC + 2);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (exp_oe == '0 && exp_out == '0 && dac_code == '0));

  assert_dac_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |->
      $past(cs_rise && word_full && addr >= 4'd1 && addr <= A_LAST));

  assert_dir_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_oe != $past(exp_oe)) |-> $past(cs_rise && word_full && addr == A_DIR));

  assert_out_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_out != $past(exp_out)) |-> $past(cs_rise && word_full && addr == A_OUT));

  assert_unused_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && word_full && (addr == 4'd0 || addr > A_OUT)) |=>
      ($stable(dac_code) && $stable(exp_oe) && $stable(exp_out)));

  assert_short_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !word_full) |=>
      ($stable(dac_code) && $stable(exp_oe) && $stable(exp_out)));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 5'd16);
endmodule

bind serial_ctl_expander serial_ctl_expander_chk #(
  .NUM_DAC(NUM_DAC), .CODE_W(CODE_W), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .word_full(word_full),
  .addr(addr), .bit_cnt(bit_cnt), .dac_code(dac_code),
  .exp_oe(exp_oe), .exp_out(exp_out)
);

// File: tb/serial_ctl_expander_test.sv
module serial_ctl_expander_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int NV = 12;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [11:0] exp_in = '0;
  logic sdo, sdo_oe;
  logic [11:0] exp_out, exp_oe;
  logic [95:0] dac_code;

  serial_ctl_expander uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .exp_in(exp_in), .exp_out(exp_out),
    .exp_oe(exp_oe), .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: [51:44] bit count, [43:12] serial data (bit 0 sent first), [11:0] pin levels
  localparam logic [51:0] VEC [NV] = '{
    {8'd16, 32'h000010A5, 12'hABC},
    {8'd16, 32'h0000C3FF, 12'h123},
    {8'd16, 32'h00006F12, 12'hFFF},
    {8'd16, 32'h0000D5A3, 12'h000},
    {8'd16, 32'h0000E3C7, 12'h555},
    {8'd16, 32'h00000FFF, 12'hAAA},
    {8'd16, 32'h0000FFFF, 12'h0F0},
    {8'd15, 32'h00001055, 12'h00F},
    {8'd0,  32'h00000000, 12'h111},
    {8'd20, 32'h0002077F, 12'h9C3},
    {8'd24, 32'h00DFFF00, 12'h246},
    {8'd16, 32'h00007000, 12'h800}
  };

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] rb_got;
  logic oe_during;
  logic [95:0] m_dac = '0;
  logic [11:0] m_oe = '0, m_out = '0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wcyc(H);
    oe_during = sdo_oe;
  endtask

  task automatic shift_bits(input logic [31:0] data, input int n);
    for (int i = 0; i < n; i++) begin
      rb_got[i] = sdo;
      sdi = data[i];
      wcyc(H);
      sclk = 1'b1;
      wcyc(H);
      sclk = 1'b0;
      wcyc(H);
    end
  endtask

  task automatic cs_high();
    csn = 1'b1;
    wcyc(H);
  endtask

  task automatic check_outputs(input string tag);
    check(dac_code == m_dac, tag, dac_code, m_dac);
    check(exp_oe == m_oe, tag, exp_oe, m_oe);
    check(exp_out == m_out, tag, exp_out, m_out);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wcyc(3);
    // R1: reset state
    check(exp_oe == '0 && exp_out == '0 && dac_code == '0, "R1 reset regs",
          {exp_oe, exp_out, dac_code}, '0);
    check(sdo_oe == 1'b0, "R1 sdo_oe in reset", sdo_oe, 1'b0);
    rst_n = 1'b1;
    wcyc(4);
    check(sdo_oe == 1'b0, "R8 sdo_oe idle", sdo_oe, 1'b0);

    for (int v = 0; v < NV; v++) begin
      automatic int n = int'(VEC[v][51:44]);
      automatic logic [31:0] d = VEC[v][43:12];
      automatic logic [11:0] pins = VEC[v][11:0];
      automatic logic [15:0] w = '0;
      automatic logic [31:0] rb_exp = '0;
      automatic logic [31:0] mask = '0;
      automatic string tag;
      exp_in = pins;
      wcyc(4);
      cs_low();
      shift_bits(d, n);
      cs_high();
      check(oe_during == 1'b1, "R8 sdo_oe during frame", oe_during, 1'b1);
      for (int i = 0; i < n; i++) begin
        mask[i] = 1'b1;
        rb_exp[i] = (i < 12) ? pins[i] : ((i < 16) ? 1'b0 : d[i-16]);
      end
      if (n > 0)
        check((rb_got & mask) == rb_exp, (n > 16) ? "R10 chained sdo" : "R9 readback",
              rb_got & mask, rb_exp);
      if (n >= 16) begin
        w = 16'(d >> (n - 16));
        if (w[15:12] >= 4'd1 && w[15:12] <= 4'd12) m_dac[(int'(w[15:12]) - 1)*8 +: 8] = w[7:0];
        else if (w[15:12] == 4'd13) m_oe = w[11:0];
        else if (w[15:12] == 4'd14) m_out = w[11:0];
      end
      if (n < 16) tag = "R6 short frame";
      else if (n > 16) tag = "R10 long frame";
      else if (w[15:12] == 4'd13) tag = "R3 direction";
      else if (w[15:12] == 4'd14) tag = "R4 output data";
      else if (w[15:12] == 4'd0 || w[15:12] == 4'd15) tag = "R5 unused addr";
      else tag = "R2 channel load";
      check_outputs(tag);
    end

    // R7: nothing changes until select rises
    cs_low();
    shift_bits(32'h0000E0F0, 16);
    check(exp_out == m_out, "R7 no early commit", exp_out, m_out);
    cs_high();
    m_out = 12'h0F0;
    check(exp_out == m_out, "R7 commit at select rise", exp_out, m_out);

    // R1: reset again clears everything
    rst_n = 1'b0;
    wcyc(2);
    m_dac = '0; m_oe = '0; m_out = '0;
    check_outputs("R1 reset after traffic");
    rst_n = 1'b1;
    wcyc(4);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule